// File: doc/BRIEF.md
# Bit-Manipulation Integer ALU

A purely combinational 64-bit integer ALU. It takes two operands and a 7-bit operation code. It returns a 64-bit result and a flag that reports whether a branch condition holds. It covers add, subtract, compare, min/max, logic, shifts, rotates, single-bit operations, shift-and-add, byte-level helpers and the 32-bit word forms, whose results are sign-extended.

The code space is grouped: bits [6:4] of the code choose a family. In the branch family, the remaining bits form a small field: a compare kind and an invert flag. An issue stage drives `op`, `a` and `b`, and reads `res` and `br_taken` in the same cycle. Any code that is not listed below gives zero on both outputs.

Top module: `bmalu`

## Requirements
- R1: Add family (bits [6:4]=010): 0100001 gives a+b. 0100000 gives zero-extended a[31:0] plus b. Codes 0101001, 0101011, 0101101 and 0101111 give (a<<1)+b, (a<<2)+b, (a<<3)+b and (a<<4)+b. Codes 0101000, 0101010 and 0101100 first zero-extend a[31:0] and then shift it left by 1, 2 or 3 before adding b.
- R2: Word family (bits [6:4]=001): 0010000 adds, 0010010 subtracts, 0011000 shifts left, 0011001 shifts right logically and 0011010 shifts right arithmetically. Each works on a[31:0], takes its shift amount from b[4:0], and sign-extends bit 31 of the 32-bit result into bits [63:32].
- R3: 64-bit shifts take their amount from b[5:0]. Code 0000001 shifts left, 0000101 shifts right logically and 0000111 shifts right arithmetically.
- R4: Rotates: 0001001 rotates a left by b[5:0] and 0001011 rotates it right. Codes 0011100 and 0011101 rotate a[31:0] left or right by b[4:0] and sign-extend the 32-bit result.
- R5: Single-bit operations use the bit index b[5:0]. Code 0000010 clears that bit of a, 0000011 sets it and 0000100 flips it. Code 0000110 returns that bit of a in bit 0, with all other result bits zero.
- R6: Compare family (bits [6:4]=011): 0110000 gives a-b. Code 0110001 gives 1 when a<b unsigned and 0 otherwise; 0110010 does the same for a signed compare. Codes 0110100 and 0110101 give the unsigned max and min; 0110110 and 0110111 give the signed max and min.
- R7: Logic: 1000000 gives a&b, 1000001 gives a&~b, 1000010 gives a|b, 1000011 gives a|~b, 1000100 gives a^b and 1000101 gives ~(a^b).
- R8: Code 1000110 sets each byte of the result to FF when the matching byte of a is non-zero and to 00 otherwise. Code 1001000 sign-extends a[7:0] and 1001010 sign-extends a[15:0].
- R9: Code 1010001 reverses the order of the eight bytes of a.
- R10: Branch codes have bits [6:4]=111; bit 0 is ignored. Bits [3:2] select the compare: 00 tests a==b, 10 tests signed a<b and 11 tests unsigned a<b. Bit 1=1 inverts the outcome. `br_taken` carries the outcome and `res` is zero. A branch code with bits [3:2]=01 gives zero on both outputs.
- R11: For every code outside the branch family, `br_taken` is 0.
- R12: Every code not named in R1 to R10 gives `res`=0 and `br_taken`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 7 | Operation code |
| a | input | 64 | First operand |
| b | input | 64 | Second operand, also the shift amount or bit index |
| res | output | 64 | Result |
| br_taken | output | 1 | Branch condition outcome |

## Verification
The hardest cases to reach are the edges where shift amounts, signs and word boundaries meet. Examples are a rotate by zero, where the complementary shift becomes a full-width shift; signed compares between operands of opposite sign; and word results whose bit 31 is set. The stimulus covers all 128 codes. It crosses each code with every pair from a list of corner operands (zero, all ones, each sign boundary at 32 and 64 bits, shift amounts 0, 31, 32 and 63). It then repeats with pseudo-random pairs, so undefined codes and the reserved branch kind are exercised too.

// File: rtl/bmalu.sv
module bmalu (
  input  logic [6:0]  op,
  input  logic [63:0] a,
  input  logic [63:0] b,
  output logic [63:0] res,
  output logic        br_taken
);
  logic [5:0]  s6;
  logic [4:0]  s5;
  logic [31:0] aw;
  logic [64:0] diff;
  logic        ult, slt, eq;
  logic [63:0] bmask, orc, rev;
  logic [31:0] w_add, w_sub, w_sll, w_srl, w_sra, w_rol, w_ror;
  logic [63:0] azx;

  assign s6    = b[5:0];
  assign s5    = b[4:0];
  assign aw    = a[31:0];
  assign azx   = {32'd0, aw};
  assign diff  = {1'b0, a} - {1'b0, b};
  assign ult   = diff[64];
  assign slt   = (a[63] ^ b[63]) ? a[63] : diff[63];
  assign eq    = (a == b);
  assign bmask = 64'd1 << s6;

  assign w_add = aw + b[31:0];
  assign w_sub = aw - b[31:0];
  assign w_sll = aw << s5;
  assign w_srl = aw >> s5;
  assign w_sra = $signed(aw) >>> s5;
  assign w_rol = (aw << s5) | (aw >> (6'd32 - {1'b0, s5}));
  assign w_ror = (aw >> s5) | (aw << (6'd32 - {1'b0, s5}));

  for (genvar i = 0; i < 8; i++) begin : g_byte
    assign orc[8*i +: 8] = {8{|a[8*i +: 8]}};
    assign rev[8*i +: 8] = a[8*(7-i) +: 8];
  end

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  always_comb begin
    res = 64'd0;
    case (op)
      7'b0000001: res = a << s6;
      7'b0000010: res = a & ~bmask;
      7'b0000011: res = a | bmask;
      7'b0000100: res = a ^ bmask;
      7'b0000101: res = a >> s6;
      7'b0000110: res = {63'd0, a[s6]};
      7'b0000111: res = $signed(a) >>> s6;
      7'b0001001: res = (a << s6) | (a >> (7'd64 - {1'b0, s6}));
      7'b0001011: res = (a >> s6) | (a << (7'd64 - {1'b0, s6}));
      7'b0010000: res = sx32(w_add);
      7'b0010010: res = sx32(w_sub);
      7'b0011000: res = sx32(w_sll);
      7'b0011001: res = sx32(w_srl);
      7'b0011010: res = sx32(w_sra);
      7'b0011100: res = sx32(w_rol);
      7'b0011101: res = sx32(w_ror);
      7'b0100000: res = azx + b;
      7'b0100001: res = a + b;
      7'b0101000: res = (azx << 1) + b;
      7'b0101001: res = (a << 1) + b;
      7'b0101010: res = (azx << 2) + b;
      7'b0101011: res = (a << 2) + b;
      7'b0101100: res = (azx << 3) + b;
      7'b0101101: res = (a << 3) + b;
      7'b0101111: res = (a << 4) + b;
      7'b0110000: res = diff[63:0];
      7'b0110001: res = {63'd0, ult};
      7'b0110010: res = {63'd0, slt};
      7'b0110100: res = ult ? b : a;
      7'b0110101: res = ult ? a : b;
      7'b0110110: res = slt ? b : a;
      7'b0110111: res = slt ? a : b;
      7'b1000000: res = a & b;
      7'b1000001: res = a & ~b;
      7'b1000010: res = a | b;
      7'b1000011: res = a | ~b;
      7'b1000100: res = a ^ b;
      7'b1000101: res = ~(a ^ b);
      7'b1000110: res = orc;
      7'b1001000: res = {{56{a[7]}}, a[7:0]};
      7'b1001010: res = {{48{a[15]}}, a[15:0]};
      7'b1010001: res = rev;
      default:    res = 64'd0;
    endcase
  end

  always_comb begin
    br_taken = 1'b0;
    if (op[6:4] == 3'b111) begin
      case (op[3:2])
        2'b00:   br_taken = eq  ^ op[1];
        2'b10:   br_taken = slt ^ op[1];
        2'b11:   br_taken = ult ^ op[1];
        default: br_taken = 1'b0;
      endcase
    end
  end
endmodule

module bmalu_chk (
  input logic [6:0]  op,
  input logic [63:0] a,
  input logic [63:0] b,
  input logic [63:0] res,
  input logic        br_taken
);
  always_comb begin
    if (op[6:4] == 3'b111)
      p_branch_res_zero_r10: assert (res == 64'd0);
    if (op[6:4] != 3'b111)
      p_no_taken_outside_r11: assert (!br_taken);
    if (op[6:4] == 3'b001)
      p_word_sign_ext_r2: assert (res[63:31] == 33'd0 || res[63:31] == {33{1'b1}});
    if (op == 7'b0110001 || op == 7'b0110010)
      p_setless_bool_r6: assert (res[63:1] == 63'd0);
    if (op[6:2] == 5'b01101)
      p_minmax_pick_r6: assert (res == a || res == b);
    if (op == 7'b0000110)
      p_bitext_bool_r5: assert (res[63:1] == 63'd0);
  end
endmodule

bind bmalu bmalu_chk u_chk (.op(op), .a(a), .b(b), .res(res), .br_taken(br_taken));

// File: tb/bmalu_tb.sv
module bmalu_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic [6:0]  op;
  logic [63:0] a, b;
  logic [63:0] res;
  logic        br_taken;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmalu u_dut (.op(op), .a(a), .b(b), .res(res), .br_taken(br_taken));

  function automatic logic [63:0] sext32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [31:0] rot32(input logic [31:0] v, input int n, input bit left);
    logic [63:0] d = {v, v};
    if (left) return d[63 - n -: 32];
    return d[n +: 32];
  endfunction

  function automatic logic [64:0] ref_model(input logic [6:0] o, input logic [63:0] x, input logic [63:0] y);
    logic [63:0] r = 64'd0;
    logic t = 1'b0;
    int n6 = int'(y[5:0]);
    int n5 = int'(y[4:0]);
    logic [127:0] dd = {x, x};
    bit sl = $signed(x) < $signed(y);
    bit ul = x < y;
    logic [63:0] zx = {32'd0, x[31:0]};
    case (o)
      7'h01: r = x << n6;
      7'h02: begin r = x; r[n6] = 1'b0; end
      7'h03: begin r = x; r[n6] = 1'b1; end
      7'h04: begin r = x; r[n6] = ~x[n6]; end
      7'h05: r = x >> n6;
      7'h06: r = {63'd0, x[n6]};
      7'h07: begin
        r = x >> n6;
        for (int i = 0; i < 64; i++) if (i >= 64 - n6) r[i] = x[63];
      end
      7'h09: r = dd[127 - n6 -: 64];
      7'h0B: r = dd[n6 +: 64];
      7'h10: r = sext32(x[31:0] + y[31:0]);
      7'h12: r = sext32(x[31:0] - y[31:0]);
      7'h18: r = sext32(x[31:0] << n5);
      7'h19: r = sext32(x[31:0] >> n5);
      7'h1A: r = sext32(32'($signed(x[31:0]) >>> n5));
      7'h1C: r = sext32(rot32(x[31:0], n5, 1'b1));
      7'h1D: r = sext32(rot32(x[31:0], n5, 1'b0));
      7'h20: r = zx + y;
      7'h21: r = x + y;
      7'h28: r = zx * 2 + y;
      7'h29: r = x * 2 + y;
      7'h2A: r = zx * 4 + y;
      7'h2B: r = x * 4 + y;
      7'h2C: r = zx * 8 + y;
      7'h2D: r = x * 8 + y;
      7'h2F: r = x * 16 + y;
      7'h30: r = x + ~y + 64'd1;
      7'h31: r = ul ? 64'd1 : 64'd0;
      7'h32: r = sl ? 64'd1 : 64'd0;
      7'h34: r = ul ? y : x;
      7'h35: r = ul ? x : y;
      7'h36: r = sl ? y : x;
      7'h37: r = sl ? x : y;
      7'h40: r = x & b_not(y, 0);
      7'h41: r = x & b_not(y, 1);
      7'h42: r = x | b_not(y, 0);
      7'h43: r = x | b_not(y, 1);
      7'h44: r = x ^ y;
      7'h45: r = x ^ ~y;
      7'h46: for (int i = 0; i < 8; i++) r[8*i +: 8] = (x[8*i +: 8] != 8'd0) ? 8'hFF : 8'h00;
      7'h48: r = 64'($signed(x[7:0]));
      7'h4A: r = 64'($signed(x[15:0]));
      7'h51: for (int i = 0; i < 8; i++) r[8*i +: 8] = x[56 - 8*i +: 8];
      default: r = 64'd0;
    endcase
    if (o[6:4] == 3'b111) begin
      r = 64'd0;
      if (o[3:2] == 2'b00) t = (x == y) != o[1];
      else if (o[3:2] == 2'b10) t = sl != o[1];
      else if (o[3:2] == 2'b11) t = ul != o[1];
    end
    return {t, r};
  endfunction

  function automatic logic [63:0] b_not(input logic [63:0] v, input bit inv);
    return inv ? ~v : v;
  endfunction

  function automatic string req_of(input logic [6:0] o);
    case (o[6:4])
      3'b111: return "R10";
      3'b001: return (o[3:1] == 3'b110) ? "R4" : "R2";
      3'b010: return "R1";
      3'b011: return "R6";
      3'b101: return (o == 7'h51) ? "R9" : "R12";
      3'b100: return (o[3:0] >= 4'h6) ? "R8" : "R7";
      3'b000: begin
        if (o == 7'h09 || o == 7'h0B) return "R4";
        if (o >= 7'h02 && o <= 7'h06 && o != 7'h05) return "R5";
        return "R3";
      end
      default: return "R12";
    endcase
  endfunction

  task automatic run_one(input logic [6:0] o, input logic [63:0] x, input logic [63:0] y);
    logic [64:0] exp;
    string tag;
    op = o; a = x; b = y;
    #1;
    exp = ref_model(o, x, y);
    tag = req_of(o);
    n_chk++;
    if (res !== exp[63:0]) begin
      n_bad++;
      $display("FAIL %s res op=%b a=%h b=%h actual=%h expected=%h", tag, o, x, y, res, exp[63:0]);
    end
    n_chk++;
    if (br_taken !== exp[64]) begin
      n_bad++;
      $display("FAIL %s br_taken (R11 when not branch) op=%b actual=%b expected=%b", tag, o, br_taken, exp[64]);
    end
  endtask

  logic [63:0] corners [12];
  logic [63:0] lfsr;

  initial begin
    corners[0]  = 64'd0;
    corners[1]  = 64'd1;
    corners[2]  = 64'hFFFF_FFFF_FFFF_FFFF;
    corners[3]  = 64'h8000_0000_0000_0000;
    corners[4]  = 64'h7FFF_FFFF_FFFF_FFFF;
    corners[5]  = 64'h0000_0000_8000_0000;
    corners[6]  = 64'h0000_0000_7FFF_FFFF;
    corners[7]  = 64'd31;
    corners[8]  = 64'd32;
    corners[9]  = 64'd63;
    corners[10] = 64'h0123_4567_89AB_CDEF;
    corners[11] = 64'hFF00_00A5_0000_1E40;
    op = 7'd0; a = 64'd0; b = 64'd0;
    #1;
    n_chk++;
    if (res !== 64'd0 || br_taken !== 1'b0) begin
      n_bad++;
      $display("FAIL R12 idle code actual=%h/%b expected=0/0", res, br_taken);
    end
    for (int o = 0; o < 128; o++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          run_one(7'(o), corners[i], corners[j]);
    lfsr = 64'hACE1_2345_6789_BEEF;
    for (int k = 0; k < 64; k++) begin
      logic [63:0] x, y;
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      x = lfsr * 64'h9E37_79B9_7F4A_7C15;
      y = {lfsr[31:0], lfsr[63:32]} ^ (x >> 7);
      for (int o = 0; o < 128; o++) run_one(7'(o), x, y);
      for (int o = 112; o < 128; o++) run_one(7'(o), x, x);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule